// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits beside the fetch stage of a 32-bit RISC core and handles the control-state side of taking and leaving an exception. Each cycle it looks at a mask of pending exception causes and picks the one with the lowest index. For that cause it stores the current program counter in the link register that belongs to the cause's class. It also records whether interrupts were enabled, clears the global interrupt enable, and issues a redirect to the cause's vector. Vectors are placed 32 bytes apart. They are counted from either the normal vector base or the debug vector base.

Breakpoint and watchpoint causes form the debug class. They have their own link register and their own saved-enable bit, and they always vector from the debug base. The normal class is bus errors, divide by zero, external interrupt and system call. Its causes vector from the normal base unless the remap control input is set, in which case they vector from the debug base instead. Two return strobes restore the global enable from the matching saved bit and redirect to the matching link register. The core writes the enable register through a plain write port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the enable bits `ie_o`, both link registers, `target_o`, `redir_o` and `err_o` are all zero.
- R2: When several bits of `exc_pend_i` are set, the cause with the lowest bit index is the only one taken.
- R3: A normal cause is taken when the remap control input is low. The normal causes are 2 (instruction bus error), 4 (data bus error), 5 (divide by zero), 6 (interrupt) and 7 (system call). The block writes `pc_i` into `ea_o` and redirects to `eba_i + index*32`. `ba_o` does not change.
- R4: If `remap_i` is high, a normal cause redirects to `deba_i + index*32` instead.
- R5: A debug cause writes `pc_i` into `ba_o` and redirects to `deba_i + index*32` whatever the value of `remap_i`. The debug causes are 1 (breakpoint) and 3 (watchpoint). `ea_o` does not change.
- R6: On entry, the global enable is `ie_o[0]`. If it is set, the class's saved bit is set: `ie_o[1]` for normal causes, `ie_o[2]` for debug causes. The global enable is then cleared. If the global enable was already clear, the saved bits keep their previous values.
- R7: Cause 0 (reset) redirects to `eba_i` and clears `ie_o[0]`. It leaves both link registers and both saved bits unchanged.
- R8: If the winning cause index is 8 or higher, `err_o` pulses and no redirect is issued. The enable bits and link registers stay unchanged, even if a return or write happens in the same cycle.
- R9: `eret_i` copies `ie_o[1]` into `ie_o[0]` and redirects to `ea_o`. `bret_i` copies `ie_o[2]` into `ie_o[0]` and redirects to `ba_o`. If both arrive together, `bret_i` wins.
- R10: A pending exception takes precedence over a return strobe and over an enable write in the same cycle. An enable write with no other event loads `ie_wdata_i` and does not redirect.
- R11: All results appear in the cycle after the stimulus. `redir_o` and `err_o` stay high for one cycle only and are low after a cycle with no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | Program counter of the instruction being interrupted |
| exc_pend_i | input | 16 | Pending cause mask, bit n = cause index n |
| eba_i | input | 32 | Normal vector base |
| deba_i | input | 32 | Debug vector base |
| remap_i | input | 1 | Sends normal causes to the debug base |
| eret_i | input | 1 | Return from normal exception |
| bret_i | input | 1 | Return from debug exception |
| ie_wr_i | input | 1 | Write strobe for the enable register |
| ie_wdata_i | input | 3 | Write data {saved debug, saved normal, global} |
| ie_o | output | 3 | Enable register {saved debug, saved normal, global} |
| ea_o | output | 32 | Normal-class link register |
| ba_o | output | 32 | Debug-class link register |
| redir_o | output | 1 | One-cycle fetch redirect pulse |
| target_o | output | 32 | Redirect address, valid with `redir_o` |
| err_o | output | 1 | Undefined-cause pulse |

## Verification
Every result of this block comes from one register stage. The redirect pulse, the target, the error pulse, the enable bits and the link registers all change at the first rising edge after the stimulus is applied. The bench drives each event on a falling edge and samples on the next falling edge, which is half a cycle after the update. It then removes the stimulus. One cycle later it confirms that the pulses have dropped. Enable-register preloads go through the write port one cycle before each event. As a result, the state that an event reads is always already settled.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // positions inside the enable register
  localparam int IE_GLB = 0;
  localparam int IE_SAV_N = 1;
  localparam int IE_SAV_D = 2;
  localparam int IE_W = 3;

  // cause indices; index order is the priority order
  localparam int C_RESET = 0;
  localparam int C_BRKPT = 1;
  localparam int C_IBUS = 2;
  localparam int C_WATCH = 3;
  localparam int C_DBUS = 4;
  localparam int C_DIV0 = 5;
  localparam int C_IRQ = 6;
  localparam int C_SCALL = 7;

  typedef enum logic [1:0] {
    CLS_RESET = 2'd0,
    CLS_NORM = 2'd1,
    CLS_DBG = 2'd2,
    CLS_BAD = 2'd3
  } exc_cls_e;

  function automatic exc_cls_e cls_of(input int unsigned idx, input int unsigned n_def);
    if (idx >= n_def) return CLS_BAD;
    if (idx == C_RESET) return CLS_RESET;
    if (idx == C_BRKPT || idx == C_WATCH) return CLS_DBG;
    return CLS_NORM;
  endfunction
endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
  parameter int W = 16,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/exc_vec.sv
module exc_vec #(
  parameter int AW = 32,
  parameter int IW = 4,
  parameter int VEC_SHIFT = 5
) (
  input  logic [IW-1:0] idx_i,
  input  exc_pkg::exc_cls_e cls_i,
  input  logic          remap_i,
  input  logic [AW-1:0] eba_i,
  input  logic [AW-1:0] deba_i,
  output logic [AW-1:0] vec_o
);
  import exc_pkg::*;
  logic [AW-1:0] base;
  logic [AW-1:0] offs;

  always_comb begin
    if (cls_i == CLS_DBG || (cls_i == CLS_NORM && remap_i)) base = deba_i;
    else base = eba_i;
    offs = AW'(idx_i) << VEC_SHIFT;
    vec_o = base + offs;
  end
endmodule

// File: rtl/exc_state.sv
module exc_state #(
  parameter int AW = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_exc_i,
  input  exc_pkg::exc_cls_e cls_i,
  input  logic [AW-1:0] vec_i,
  input  logic [AW-1:0] pc_i,
  input  logic eret_i,
  input  logic bret_i,
  input  logic ie_wr_i,
  input  logic [exc_pkg::IE_W-1:0] ie_wdata_i,
  output logic [exc_pkg::IE_W-1:0] ie_q,
  output logic [AW-1:0] ea_q,
  output logic [AW-1:0] ba_q,
  output logic redir_q,
  output logic [AW-1:0] tgt_q,
  output logic err_q
);
  import exc_pkg::*;
  logic [IE_W-1:0] ie_n;
  logic [AW-1:0] ea_n, ba_n, tgt_n;
  logic redir_n, err_n, st_en;

  assign st_en = ev_exc_i | eret_i | bret_i | ie_wr_i;

  always_comb begin
    ie_n = ie_q;
    ea_n = ea_q;
    ba_n = ba_q;
    tgt_n = tgt_q;
    redir_n = 1'b0;
    err_n = 1'b0;
    if (ev_exc_i) begin
      if (cls_i == CLS_BAD) begin
        err_n = 1'b1;
      end else begin
        redir_n = 1'b1;
        tgt_n = vec_i;
        ie_n[IE_GLB] = 1'b0;
        if (cls_i == CLS_DBG) begin
          ba_n = pc_i;
          if (ie_q[IE_GLB]) ie_n[IE_SAV_D] = 1'b1;
        end else if (cls_i == CLS_NORM) begin
          ea_n = pc_i;
          if (ie_q[IE_GLB]) ie_n[IE_SAV_N] = 1'b1;
        end
      end
    end else if (bret_i) begin
      redir_n = 1'b1;
      tgt_n = ba_q;
      ie_n[IE_GLB] = ie_q[IE_SAV_D];
    end else if (eret_i) begin
      redir_n = 1'b1;
      tgt_n = ea_q;
      ie_n[IE_GLB] = ie_q[IE_SAV_N];
    end else if (ie_wr_i) begin
      ie_n = ie_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
      ea_q <= '0;
      ba_q <= '0;
      tgt_q <= '0;
    end else if (st_en) begin
      ie_q <= ie_n;
      ea_q <= ea_n;
      ba_q <= ba_n;
      tgt_q <= tgt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      redir_q <= redir_n;
      err_q <= err_n;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int AW = 32,
  parameter int CAUSE_W = 4,
  parameter int NUM_DEF = 8,
  parameter int VEC_SHIFT = 5,
  localparam int PEND_W = 1 << CAUSE_W,
  localparam int IEW = exc_pkg::IE_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [AW-1:0] pc_i,
  input  logic [PEND_W-1:0] exc_pend_i,
  input  logic [AW-1:0] eba_i,
  input  logic [AW-1:0] deba_i,
  input  logic remap_i,
  input  logic eret_i,
  input  logic bret_i,
  input  logic ie_wr_i,
  input  logic [IEW-1:0] ie_wdata_i,
  output logic [IEW-1:0] ie_o,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] ba_o,
  output logic redir_o,
  output logic [AW-1:0] target_o,
  output logic err_o
);
  import exc_pkg::*;
  logic any_pend;
  logic [CAUSE_W-1:0] win_idx;
  exc_cls_e win_cls;
  logic [AW-1:0] vec;

  exc_prio #(.W(PEND_W)) u_prio (
    .req_i(exc_pend_i), .any_o(any_pend), .idx_o(win_idx)
  );

  assign win_cls = cls_of(32'(win_idx), NUM_DEF);

  exc_vec #(.AW(AW), .IW(CAUSE_W), .VEC_SHIFT(VEC_SHIFT)) u_vec (
    .idx_i(win_idx), .cls_i(win_cls), .remap_i(remap_i),
    .eba_i(eba_i), .deba_i(deba_i), .vec_o(vec)
  );

  exc_state #(.AW(AW)) u_state (
    .clk(clk), .rst_n(rst_n), .ev_exc_i(any_pend), .cls_i(win_cls),
    .vec_i(vec), .pc_i(pc_i), .eret_i(eret_i), .bret_i(bret_i),
    .ie_wr_i(ie_wr_i), .ie_wdata_i(ie_wdata_i), .ie_q(ie_o), .ea_q(ea_o),
    .ba_q(ba_o), .redir_q(redir_o), .tgt_q(target_o), .err_q(err_o)
  );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int AW = 32,
  parameter int PEND_W = 16,
  parameter int NUM_DEF = 8
) (
  input logic clk,
  input logic rst_n,
  input logic [AW-1:0] pc_i,
  input logic [PEND_W-1:0] exc_pend_i,
  input logic [AW-1:0] eba_i,
  input logic remap_i,
  input logic eret_i,
  input logic bret_i,
  input logic [2:0] ie_o,
  input logic [AW-1:0] ea_o,
  input logic [AW-1:0] ba_o,
  input logic redir_o,
  input logic [AW-1:0] target_o,
  input logic err_o
);
  // R3
  ibus_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_pend_i == PEND_W'(4) && !remap_i) |=>
      (redir_o && target_o == $past(eba_i) + AW'(64) && ea_o == $past(pc_i)));
  // R5
  brk_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_pend_i[1] && !exc_pend_i[0]) |=> (ba_o == $past(pc_i) && $stable(ea_o)));
  // R6
  irq_ie_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_pend_i == PEND_W'(64) && ie_o[0]) |=> (ie_o[1] && !ie_o[0]));
  // R8
  bad_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|exc_pend_i) && exc_pend_i[NUM_DEF-1:0] == '0) |=>
      (err_o && !redir_o && $stable(ie_o) && $stable(ea_o) && $stable(ba_o)));
  // R9
  eret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !bret_i && exc_pend_i == '0) |=> (redir_o && ie_o[0] == $past(ie_o[1]) && target_o == ea_o));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_pend_i == '0 && !eret_i && !bret_i) |=> (!redir_o && !err_o));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW), .PEND_W(PEND_W), .NUM_DEF(NUM_DEF)) chk_i (
  .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .exc_pend_i(exc_pend_i), .eba_i(eba_i),
  .remap_i(remap_i), .eret_i(eret_i), .bret_i(bret_i), .ie_o(ie_o), .ea_o(ea_o),
  .ba_o(ba_o), .redir_o(redir_o), .target_o(target_o), .err_o(err_o)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] pc_i = '0, eba_i = 32'h0000_1000, deba_i = 32'h0000_8000;
  logic [15:0] exc_pend_i = '0;
  logic remap_i = 1'b0, eret_i = 1'b0, bret_i = 1'b0, ie_wr_i = 1'b0;
  logic [2:0] ie_wdata_i = '0;
  logic [2:0] ie_o;
  logic [31:0] ea_o, ba_o, target_o;
  logic redir_o, err_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .exc_pend_i(exc_pend_i), .eba_i(eba_i),
    .deba_i(deba_i), .remap_i(remap_i), .eret_i(eret_i), .bret_i(bret_i),
    .ie_wr_i(ie_wr_i), .ie_wdata_i(ie_wdata_i), .ie_o(ie_o), .ea_o(ea_o),
    .ba_o(ba_o), .redir_o(redir_o), .target_o(target_o), .err_o(err_o)
  );

  // {ie_pre[3], remap[1], pend[16], target[32], ie_exp[3], link[2] 0 none 1 ea 2 ba, redir[1], err[1]}
  localparam int NV = 11;
  localparam logic [58:0] VEC [NV] = '{
    {3'b001, 1'b0, 16'h0004, 32'h0000_1040, 3'b010, 2'd1, 1'b1, 1'b0}, // R3 R6
    {3'b001, 1'b1, 16'h0040, 32'h0000_80C0, 3'b010, 2'd1, 1'b1, 1'b0}, // R4
    {3'b001, 1'b1, 16'h0002, 32'h0000_8020, 3'b100, 2'd2, 1'b1, 1'b0}, // R5 R6
    {3'b000, 1'b0, 16'h0008, 32'h0000_8060, 3'b000, 2'd2, 1'b1, 1'b0}, // R5
    {3'b010, 1'b0, 16'h0080, 32'h0000_10E0, 3'b010, 2'd1, 1'b1, 1'b0}, // R6
    {3'b001, 1'b0, 16'h00B0, 32'h0000_1080, 3'b010, 2'd1, 1'b1, 1'b0}, // R2
    {3'b101, 1'b0, 16'h0030, 32'h0000_1080, 3'b110, 2'd1, 1'b1, 1'b0}, // R2 R6
    {3'b001, 1'b1, 16'h0001, 32'h0000_1000, 3'b000, 2'd0, 1'b1, 1'b0}, // R7
    {3'b001, 1'b0, 16'h0100, 32'h0000_0000, 3'b001, 2'd0, 1'b0, 1'b1}, // R8
    {3'b001, 1'b1, 16'h00A0, 32'h0000_80A0, 3'b010, 2'd1, 1'b1, 1'b0}, // R2 R4
    {3'b100, 1'b0, 16'h000A, 32'h0000_8020, 3'b100, 2'd2, 1'b1, 1'b0}  // R2 R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_ie(input logic [2:0] v);
    @(negedge clk);
    ie_wr_i = 1'b1;
    ie_wdata_i = v;
    @(negedge clk);
    ie_wr_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] ea_prev, ba_prev, pc_v;
    repeat (3) @(negedge clk);
    check("R1 ie", 32'(ie_o), 0);
    check("R1 redir", 32'(redir_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ie", 32'(ie_o), 0);
    check("R1 ea", ea_o, 0);
    check("R1 ba", ba_o, 0);
    check("R1 target", target_o, 0);
    check("R1 err", 32'(err_o), 0);

    for (int k = 0; k < NV; k++) begin
      logic [58:0] v;
      v = VEC[k];
      write_ie(v[58:56]);
      ea_prev = ea_o;
      ba_prev = ba_o;
      pc_v = 32'hC000_0000 + 32'(k * 16);
      pc_i = pc_v;
      remap_i = v[55];
      exc_pend_i = v[54:39];
      @(negedge clk);
      exc_pend_i = '0;
      check("R11 redir", 32'(redir_o), 32'(v[1]));
      check("R8 err", 32'(err_o), 32'(v[0]));
      check("R6 ie", 32'(ie_o), 32'(v[6:4]));
      if (v[1]) check("R3 R4 R5 R7 target", target_o, v[38:7]);
      check("R3 R7 ea", ea_o, (v[3:2] == 2'd1) ? pc_v : ea_prev);
      check("R5 R7 ba", ba_o, (v[3:2] == 2'd2) ? pc_v : ba_prev);
      @(negedge clk);
      check("R11 pulse drop", 32'({redir_o, err_o}), 0);
    end
    remap_i = 1'b0;

    // R9 normal return
    write_ie(3'b010);
    eret_i = 1'b1;
    @(negedge clk);
    eret_i = 1'b0;
    check("R9 eret ie", 32'(ie_o), 32'b011);
    check("R9 eret target", target_o, ea_o);
    check("R9 eret redir", 32'(redir_o), 1);

    // R9 debug return
    write_ie(3'b100);
    bret_i = 1'b1;
    @(negedge clk);
    bret_i = 1'b0;
    check("R9 bret ie", 32'(ie_o), 32'b101);
    check("R9 bret target", target_o, ba_o);

    // R9 both returns: debug wins
    write_ie(3'b100);
    eret_i = 1'b1;
    bret_i = 1'b1;
    @(negedge clk);
    eret_i = 1'b0;
    bret_i = 1'b0;
    check("R9 both ie", 32'(ie_o), 32'b101);
    check("R9 both target", target_o, ba_o);

    // R10 exception beats return
    write_ie(3'b001);
    pc_i = 32'h0000_4444;
    exc_pend_i = 16'h0040;
    eret_i = 1'b1;
    @(negedge clk);
    exc_pend_i = '0;
    eret_i = 1'b0;
    check("R10 target", target_o, 32'h0000_10C0);
    check("R10 ie", 32'(ie_o), 32'b010);
    check("R10 ea", ea_o, 32'h0000_4444);

    // R10 exception beats ie write
    @(negedge clk);
    ie_wr_i = 1'b1;
    ie_wdata_i = 3'b111;
    exc_pend_i = 16'h0004;
    @(negedge clk);
    ie_wr_i = 1'b0;
    exc_pend_i = '0;
    check("R10 write ignored", 32'(ie_o), 32'b010);

    // R10 plain write, no redirect
    @(negedge clk);
    ie_wr_i = 1'b1;
    ie_wdata_i = 3'b111;
    @(negedge clk);
    ie_wr_i = 1'b0;
    check("R10 write ie", 32'(ie_o), 32'b111);
    check("R10 write redir", 32'(redir_o), 0);

    // R8 bad cause with return: nothing moves
    ea_prev = ea_o;
    exc_pend_i = 16'h0200;
    eret_i = 1'b1;
    @(negedge clk);
    exc_pend_i = '0;
    eret_i = 1'b0;
    check("R8 err", 32'(err_o), 1);
    check("R8 ie", 32'(ie_o), 32'b111);
    check("R8 ea", ea_o, ea_prev);
    check("R8 redir", 32'(redir_o), 0);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule